// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for a memory built from 4 KB pages. It keeps a few cached page mappings, each tying a 20-bit virtual page number to a physical page number. The width of the physical page number comes from the size of the memory. On a hit, the translated page number is joined to the 12-bit page offset, and the response appears in the same cycle as the request. The offset is never altered.

On a miss, the block holds the request and raises a walk request toward an external refill agent. While the walk is pending, the block refuses new lookups. The agent answers with one fill beat that carries either a physical page number or an "absent" flag. In the cycle of that beat, the block delivers the translation or a page fault. A valid page is then installed: first into the lowest-numbered empty slot, or, when every slot is full, into the slot named by a round-robin pointer. A flush input empties the whole buffer in one cycle.

Requests use a valid/ready pair. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after a miss is taken until the cycle after the fill beat. While it is low, the block ignores requests, and the requester must hold them. The response is a single-cycle pulse with no back-pressure.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `rsp_paddr` equals the cached physical page number in bits above 11, and the request's bits 11:0 in bits 11:0. The virtual page number is `req_vaddr[31:12]`.
- R2: The physical page number is log2(MEM_BYTES/4096) bits wide. `rsp_paddr` is that width plus 12 bits (24 bits at the defaults).
- R3: When a request is taken and no valid entry matches, `rsp_valid` stays low in that cycle. From the next cycle, `walk_req` is high with `walk_vpn` equal to the missed page number, and `req_ready` is low. Both hold until the fill beat.
- R4: A fill beat (`fill_valid` while `walk_req` is high) raises `rsp_valid` in that same cycle. With `fill_absent` low, `rsp_paddr` is `{fill_ppn, missed offset}`. In the next cycle, `walk_req` is low and `req_ready` is high.
- R5: A fill beat with `fill_absent` high returns `rsp_fault` high and installs nothing, so a later request to that page misses again.
- R6: A hit needs a valid entry whose stored page number equals all 20 bits of the request's page number. Reset leaves every entry invalid.
- R7: A fill installs into the lowest-numbered invalid entry when one exists.
- R8: When all entries are valid, a fill replaces the entry named by a pointer. The pointer is 0 after reset, advances by one modulo ENTRIES after each such replacement, and is not changed by flush.
- R9: `flush` invalidates every entry at the next clock edge. A lookup taken in the same cycle as `flush` still sees the contents from before the flush.
- R10: When `flush` coincides with a fill beat, the flush wins and nothing is installed. The translation is still returned in that cycle.
- R11: While `req_ready` is low, `req_valid` and `req_vaddr` have no effect on any output.
- R12: `rsp_valid` is high only for a taken hit or a fill beat, and `rsp_fault` is high only on an absent fill beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a lookup |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | PPN_W+12 | Translated physical address |
| walk_req | output | 1 | Refill wanted for a missed page |
| walk_vpn | output | 20 | Page number to refill |
| fill_valid | input | 1 | Refill answer present |
| fill_absent | input | 1 | Page is not mapped |
| fill_ppn | input | PPN_W | Physical page number from the walk |

## Verification
Two pairs of functions can fall in the same cycle: a flush with a taken lookup, and a flush with a fill beat. The bench provokes both by raising `flush` in the very cycle of the request or of the fill. It then judges the outcome against a reference model: the response in that cycle must reflect the old contents or the fill data, and the next request to the same page must miss. A long sweep over eight page numbers with four entries drives repeated eviction. Two of those page numbers differ only in bit 31. The sweep also sends stray requests while a walk is pending.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 4,
  parameter int PPN_W   = 12,
  parameter int IDX_W   = 2,
  parameter int VPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] match;
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_vec[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_vec[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        vpn_q[g] <= wr_vpn;
        ppn_q[g] <= wr_ppn;
      end
    end
    assign match[g] = valid_vec[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end
  assign lk_hit = |match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               adv,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid_vec[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign victim_idx = free_found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (adv && !free_found) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter longint MEM_BYTES = 64'd16777216,
  parameter int PPN_W     = $clog2(MEM_BYTES / 4096),
  parameter int PA_W      = PPN_W + 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             walk_req,
  output logic [19:0]      walk_vpn,
  input  logic             fill_valid,
  input  logic             fill_absent,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               busy_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic               take, fill_beat, wr_en, lk_hit;
  logic [PPN_W-1:0]   lk_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;

  assign take      = req_valid && !busy_q;
  assign fill_beat = busy_q && fill_valid;
  assign wr_en     = fill_beat && !fill_absent && !flush;

  tlb_cam #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(victim_idx), .wr_vpn(vpn_q), .wr_ppn(fill_ppn),
    .lk_vpn(req_vaddr[VA_W-1:OFF_W]), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .valid_vec(valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .adv(wr_en),
    .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (take && !lk_hit) begin
      busy_q <= 1'b1;
    end else if (fill_beat) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      vpn_q <= req_vaddr[VA_W-1:OFF_W];
      off_q <= req_vaddr[OFF_W-1:0];
    end
  end

  assign req_ready = !busy_q;
  assign walk_req  = busy_q;
  assign walk_vpn  = vpn_q;
  assign rsp_valid = (take && lk_hit) || fill_beat;
  assign rsp_fault = fill_beat && fill_absent;
  assign rsp_paddr = busy_q ? {fill_ppn, off_q} : {lk_ppn, req_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int PPN_W = 12,
  parameter int PA_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             walk_req,
  input logic [19:0]      walk_vpn,
  input logic             fill_valid,
  input logic             fill_absent,
  input logic [PPN_W-1:0] fill_ppn
);
  AST_WALK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready); // R3
  AST_MISS_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_valid) |=> (walk_req && walk_vpn == $past(req_vaddr[31:12]))); // R3
  AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn))); // R11
  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid) |-> (rsp_valid && rsp_fault == fill_absent)); // R4
  AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid) |=> req_ready); // R4
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_ready) |-> (rsp_paddr[11:0] == req_vaddr[11:0])); // R1
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((req_valid && req_ready) || (walk_req && fill_valid))); // R12
  AST_HIT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_ready) |-> !rsp_fault); // R12
endmodule

bind tlb_xlate tlb_xlate_chk #(.PPN_W(PPN_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int NE    = 4;
  localparam int PPN_W = 12;
  localparam int PA_W  = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_vaddr = '0;
  logic             rsp_valid, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;
  logic             walk_req;
  logic [19:0]      walk_vpn;
  logic             fill_valid = 1'b0;
  logic             fill_absent = 1'b0;
  logic [PPN_W-1:0] fill_ppn = '0;

  int checks = 0;
  int fails  = 0;

  logic             m_val [NE];
  logic [19:0]      m_vpn [NE];
  logic [PPN_W-1:0] m_ppn [NE];
  int               m_ptr;

  always #5 clk = ~clk;

  tlb_xlate #(.ENTRIES(NE), .MEM_BYTES(64'd16777216)) u_tlb_xlate (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] vpn_of(input int k);
    if (k == 7) return 20'h80000 ^ vpn_of(6);
    return 20'(k * 20'h12345 + 1);
  endfunction

  function automatic logic [PPN_W-1:0] ppn_of(input logic [19:0] v);
    return PPN_W'(v * 37 + 11);
  endfunction

  function automatic logic absent_of(input int k);
    return (k == 5);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) m_val[i] = 1'b0;
  endtask

  task automatic model_fill(input logic [19:0] v, input logic [PPN_W-1:0] p);
    int slot = -1;
    for (int i = 0; i < NE; i++) if (slot < 0 && !m_val[i]) slot = i;
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % NE;
    end
    m_val[slot] = 1'b1; m_vpn[slot] = v; m_ppn[slot] = p;
  endtask

  task automatic access(input int k, input logic [11:0] off, input string tag,
                        input logic flush_req, input logic flush_fill);
    logic [19:0]      v = vpn_of(k);
    logic             hit = 1'b0;
    logic [PPN_W-1:0] hp = '0;
    logic             ab = absent_of(k);
    for (int i = 0; i < NE; i++) if (m_val[i] && m_vpn[i] == v) begin hit = 1'b1; hp = m_ppn[i]; end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {v, off}; flush = flush_req;
    #1;
    chk("R4", 32'(req_ready), 32'd1);
    chk(tag, 32'(rsp_valid), 32'(hit));
    if (hit) begin
      chk("R1", 32'(rsp_paddr), 32'({hp, off}));
      chk("R12", 32'(rsp_fault), 32'd0);
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      if (flush_req) model_clear();
    end else begin
      @(negedge clk);
      req_vaddr = ~req_vaddr; flush = 1'b0;
      if (flush_req) model_clear();
      #1;
      chk("R3", 32'(walk_req), 32'd1);
      chk("R3", 32'(walk_vpn), 32'(v));
      chk("R3", 32'(req_ready), 32'd0);
      chk("R11", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b1; fill_absent = ab;
      fill_ppn = ppn_of(v); flush = flush_fill;
      #1;
      chk("R4", 32'(rsp_valid), 32'd1);
      chk("R5", 32'(rsp_fault), 32'(ab));
      if (!ab) chk(flush_fill ? "R10" : "R4", 32'(rsp_paddr), 32'({ppn_of(v), off}));
      @(negedge clk);
      fill_valid = 1'b0; fill_absent = 1'b0; flush = 1'b0;
      if (flush_fill) model_clear();
      else if (!ab) model_fill(v, ppn_of(v));
      #1;
      chk("R4", 32'(req_ready), 32'd1);
      chk("R4", 32'(walk_req), 32'd0);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6", 32'(req_ready), 32'd1);
    chk("R12", 32'(rsp_valid), 32'd0);
    chk("R3", 32'(walk_req), 32'd0);
    chk("R2", 32'($bits(rsp_paddr)), 32'($clog2(16777216 / 4096) + 12));

    // R6 fill four pages, then hit each across offsets
    for (int k = 0; k < 4; k++) access(k, 12'(k * 291), "R6", 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 4096; o += 1365) access(k, 12'(o), "R6", 1'b0, 1'b0);
    access(0, 12'hFFF, "R1", 1'b0, 1'b0);

    // R7 R8 eviction order: slot0 (page 0) goes first, then slot1
    access(4, 12'h010, "R6", 1'b0, 1'b0);
    access(1, 12'h020, "R8", 1'b0, 1'b0);
    access(0, 12'h030, "R7", 1'b0, 1'b0);
    access(2, 12'h040, "R8", 1'b0, 1'b0);

    // R5 absent page faults and stays absent
    access(5, 12'h123, "R5", 1'b0, 1'b0);
    access(5, 12'h321, "R5", 1'b0, 1'b0);

    // R6 pages differing only in top bit
    access(6, 12'h0AA, "R6", 1'b0, 1'b0);
    access(7, 12'h0BB, "R6", 1'b0, 1'b0);
    access(6, 12'h0CC, "R6", 1'b0, 1'b0);

    // R9 flush coinciding with a hit: hit served, then everything misses
    access(6, 12'h111, "R9", 1'b1, 1'b0);
    access(6, 12'h222, "R9", 1'b0, 1'b0);
    access(7, 12'h333, "R9", 1'b0, 1'b0);

    // R10 flush coinciding with fill: translation returned, nothing kept
    access(3, 12'h444, "R10", 1'b0, 1'b1);
    access(3, 12'h555, "R10", 1'b0, 1'b0);

    // R8 sweep: long trace with repeated eviction
    for (int i = 0; i < 120; i++) access((i * 3) % 8, 12'(i * 499), "R8", 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule